// File: doc/BRIEF.md
# Serial-Controlled Successive-Approximation Converter Core

This block is the digital half of a two-input successive-approximation converter that talks to a host over a three-wire serial link: an active-low select, a serial clock and a data-in line. A data-out line is driven only while a conversion owns it, so the host may share one wire for data in and data out. The analog multiplexer, the resistor ladder and the comparator sit outside the block. The block drives them through a trial-code bus and channel-select outputs, and it reads back a single comparator bit.

The host pulls the select low and clocks in a start bit, which is the first high seen on data-in, and then two assignment bits. The block then inserts one settling period in which it drives a low. It runs an 8-step binary search, putting each decided bit on the data-out line as soon as it is known, most significant first. It then replays the result least significant first and holds the line low until the select is released. The core runs on a fast system clock. It samples the serial clock and acts on its detected rising and falling edges, and every output changes one system clock after the sample that shows the edge.

Top module: `sarlink_core`

## Requirements
- R1: While cs_n is high, all state clears. One clk later dout_en=0, dout=0, trial_code=0 and sel_valid/sel_single/sel_odd=0. The same values hold after rst.
- R2: With cs_n low, data-in is sampled on each detected sclk rise. Lows are skipped, and the first high is taken as the start bit.
- R3: The two sclk rises after the start bit capture the assignment: first a mode bit (1 = single-ended, 0 = differential), then a select bit. In single-ended mode, select 0 uses channel 0 and select 1 uses channel 1. In differential mode, select 0 makes channel 0 positive and channel 1 negative, and select 1 swaps them. After the second bit, sel_valid=1 and sel_single/sel_odd show the two bits.
- R4: Once the assignment is captured, din has no effect until cs_n rises.
- R5: On the first sclk fall after the assignment, dout_en goes to 1 and dout drives 0 (settling period).
- R6: On each of the next 8 sclk rises, trial_code becomes the bits already decided plus a 1 at the bit under test, from bit 7 down to bit 0. After each decision, trial_code holds only the decided bits.
- R7: On each of the 8 following sclk falls, cmp_in (1 = positive input at or above the trial level) decides the bit under test, and that bit appears on dout. The code is therefore output MSB first and equals the positive-minus-negative level.
- R8: On the 7 sclk falls after bit 0, dout replays bits 1 through 7 in that order. After that, dout stays 0 while cs_n is low.
- R9: When the positive input is below the negative input, every decided bit and every replayed bit is 0.
- R10: After a conversion, further sclk edges and start-like din pulses do not begin a new one while cs_n stays low. A high pulse on cs_n followed by a fresh start bit does begin one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high clears the block |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial start and assignment bits |
| cmp_in | input | 1 | Comparator decision, 1 when positive input is at or above trial level |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Drive enable for dout; 0 means high impedance |
| trial_code | output | 8 | Code applied to the external ladder |
| sel_valid | output | 1 | Multiplexer assignment is in force |
| sel_single | output | 1 | 1 = single-ended, 0 = differential |
| sel_odd | output | 1 | Channel / polarity select bit |

## Verification
The bench aims at the edge of the address phase. Leading zeros before the start bit and data-in toggling during the search would corrupt the assignment or restart the sequence in a design that kept listening to din. It checks that the settling low appears exactly one falling edge before bit 7. A design that skipped it would shift every result bit one period early. It checks that the replay starts at bit 1 rather than repeating bit 0. A design that got this wrong would output an eight-bit replay and an extra bit. Negative differential inputs must give all zeros, and a wrong polarity swap would instead produce the opposite channel's magnitude. Extra start-like pulses after a finished conversion must not trigger a second search without a select toggle.

// File: rtl/sarlink_pkg.sv
package sarlink_pkg;

    localparam int ASG_BITS = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETTLE,
        PH_CONV,
        PH_REPLAY,
        PH_TAIL
    } phase_e;

    // first shifted bit lands in the upper field
    typedef struct packed {
        logic single;
        logic odd;
    } asg_t;

    typedef struct packed {
        logic valid;
        logic single;
        logic odd;
    } mux_sel_t;

    function automatic mux_sel_t mux_decode(input logic valid, input asg_t a);
        mux_sel_t m;
        m.valid  = valid;
        m.single = valid & a.single;
        m.odd    = valid & a.odd;
        return m;
    endfunction

    function automatic logic phase_locked(input phase_e p);
        return (p == PH_SETTLE) || (p == PH_CONV) || (p == PH_REPLAY) || (p == PH_TAIL);
    endfunction

endpackage

// File: rtl/sarlink_edge.sv
module sarlink_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/sarlink_seq.sv
module sarlink_seq
    import sarlink_pkg::*;
#(
    parameter  int CODE_W = 8,
    localparam int IDX_W  = $clog2(CODE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             rise,
    input  logic             fall,
    input  logic             din,
    output phase_e           phase,
    output logic [IDX_W-1:0] bit_idx,
    output asg_t             asg,
    output logic             sel_valid
);
    localparam int CNT_W = $clog2(ASG_BITS + 1);

    phase_e              phase_q;
    logic [IDX_W-1:0]    idx_q;
    logic [ASG_BITS-1:0] asg_bits;
    logic [CNT_W-1:0]    cnt_q;
    logic                valid_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q  <= PH_IDLE;
            idx_q    <= '0;
            asg_bits <= '0;
            cnt_q    <= '0;
            valid_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (rise && din) begin
                        phase_q <= PH_ADDR;
                        cnt_q   <= '0;
                    end
                end
                PH_ADDR: begin
                    if (rise) begin
                        asg_bits <= {asg_bits[ASG_BITS-2:0], din};
                        cnt_q    <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(ASG_BITS - 1)) begin
                            phase_q <= PH_SETTLE;
                            valid_q <= 1'b1;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (fall) begin
                        phase_q <= PH_CONV;
                        idx_q   <= IDX_W'(CODE_W - 1);
                    end
                end
                PH_CONV: begin
                    if (fall) begin
                        if (idx_q == '0) begin
                            phase_q <= PH_REPLAY;
                            idx_q   <= IDX_W'(1);
                        end else begin
                            idx_q <= idx_q - IDX_W'(1);
                        end
                    end
                end
                PH_REPLAY: begin
                    if (fall) begin
                        if (idx_q == IDX_W'(CODE_W - 1)) phase_q <= PH_TAIL;
                        else                             idx_q   <= idx_q + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase     = phase_q;
    assign bit_idx   = idx_q;
    assign asg       = asg_t'(asg_bits);
    assign sel_valid = valid_q;

    // R4: assignment frozen once the search sequence owns the link
    assert_din_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_locked(phase_q) && !clear) |=> $stable(asg_bits))
        else $error("assignment changed after capture");

    // R3: selection is only valid once the address phase is over
    assert_select_after_addr_R3: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> phase_locked(phase_q))
        else $error("select valid outside conversion");

endmodule

// File: rtl/sarlink_sar.sv
module sarlink_sar
    import sarlink_pkg::*;
#(
    parameter  int CODE_W = 8,
    localparam int IDX_W  = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              rise,
    input  logic              fall,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] result
);
    logic in_conv;
    assign in_conv = (phase == PH_CONV);

    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        logic hit;
        logic res_q;
        logic trial_q;

        assign hit = (bit_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                res_q   <= 1'b0;
                trial_q <= 1'b0;
            end else if (in_conv) begin
                if (rise) begin
                    trial_q <= res_q | hit;
                end else if (fall) begin
                    if (hit) begin
                        res_q   <= cmp_in;
                        trial_q <= cmp_in;
                    end else begin
                        trial_q <= res_q;
                    end
                end
            end
        end

        assign result[i]     = res_q;
        assign trial_code[i] = trial_q;
    end

    // R8: decided code is frozen while it is replayed
    assert_result_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_REPLAY || phase == PH_TAIL) && !clear) |=> $stable(result))
        else $error("result moved during replay");

    // R6: trial code only moves on a serial clock edge of the search
    assert_trial_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(trial_code) && !$past(clear)) |-> ($past(rise) || $past(fall)))
        else $error("trial code moved without an sclk edge");

endmodule

// File: rtl/sarlink_tx.sv
module sarlink_tx
    import sarlink_pkg::*;
#(
    parameter  int CODE_W = 8,
    localparam int IDX_W  = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              fall,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [CODE_W-1:0] result,
    input  logic              cmp_in,
    output logic              dout,
    output logic              dout_en
);
    logic do_q;
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            do_q <= 1'b0;
            en_q <= 1'b0;
        end else if (fall) begin
            case (phase)
                PH_SETTLE: begin
                    en_q <= 1'b1;
                    do_q <= 1'b0;
                end
                PH_CONV:   do_q <= cmp_in;
                PH_REPLAY: do_q <= result[bit_idx];
                PH_TAIL:   do_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign dout    = do_q;
    assign dout_en = en_q;

    // R1: deselect returns the line to high impedance
    assert_release_hiz_R1: assert property (@(posedge clk) disable iff (rst)
        clear |=> !en_q)
        else $error("dout still driven after deselect");

    // R7: a driven data bit only changes after a falling sclk edge
    assert_dout_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q) && !$stable(do_q)) |-> $past(fall))
        else $error("dout changed without a falling edge");

endmodule

// File: rtl/sarlink_core.sv
module sarlink_core
    import sarlink_pkg::*;
#(
    parameter  int CODE_W = 8,
    localparam int IDX_W  = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              cmp_in,
    output logic              dout,
    output logic              dout_en,
    output logic [CODE_W-1:0] trial_code,
    output logic              sel_valid,
    output logic              sel_single,
    output logic              sel_odd
);
    logic             rise;
    logic             fall;
    logic             clear;
    phase_e           phase;
    logic [IDX_W-1:0] bit_idx;
    asg_t             asg;
    logic             valid;
    logic [CODE_W-1:0] result;
    mux_sel_t         msel;

    assign clear = cs_n;

    sarlink_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    sarlink_seq #(.CODE_W(CODE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .rise      (rise),
        .fall      (fall),
        .din       (din),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .asg       (asg),
        .sel_valid (valid)
    );

    sarlink_sar #(.CODE_W(CODE_W)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .rise       (rise),
        .fall       (fall),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .result     (result)
    );

    sarlink_tx #(.CODE_W(CODE_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .fall    (fall),
        .phase   (phase),
        .bit_idx (bit_idx),
        .result  (result),
        .cmp_in  (cmp_in),
        .dout    (dout),
        .dout_en (dout_en)
    );

    assign msel       = mux_decode(valid, asg);
    assign sel_valid  = msel.valid;
    assign sel_single = msel.single;
    assign sel_odd    = msel.odd;

    // R5: the line is never driven before a channel is selected
    assert_drive_needs_select_R5: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> sel_valid)
        else $error("dout driven without a channel selection");

endmodule

// File: tb/sarlink_core_bench.sv
module sarlink_core_bench;
    localparam int CW = 8;
    localparam int H  = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, cs_n, sclk, din, cmp_in;
    logic dout, dout_en, sel_valid, sel_single, sel_odd;
    logic [CW-1:0] trial_code;

    int ch0, ch1, pos_v, neg_v;
    int n_vec = 0;
    int n_bad = 0;

    sarlink_core #(.CODE_W(CW)) u_sarlink_core (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .din        (din),
        .cmp_in     (cmp_in),
        .dout       (dout),
        .dout_en    (dout_en),
        .trial_code (trial_code),
        .sel_valid  (sel_valid),
        .sel_single (sel_single),
        .sel_odd    (sel_odd)
    );

    // analog side: multiplexer plus comparator
    always_comb begin
        pos_v  = sel_odd ? ch1 : ch0;
        neg_v  = sel_single ? 0 : (sel_odd ? ch0 : ch1);
        cmp_in = sel_valid && ((pos_v - neg_v) >= int'(trial_code));
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic m_prev = 1'b0;
    int   m_stage, m_rc, m_fc, m_code;
    logic m_single;
    logic e_en, e_do, e_valid, e_single, e_odd;
    logic [CW-1:0] e_trial;
    bit   q[$];

    always @(posedge clk) begin
        logic r, f;
        int b, diff;
        r = sclk && !m_prev;
        f = !sclk && m_prev;
        m_prev = sclk;
        if (rst || cs_n) begin
            m_stage = 0; m_rc = 0; m_fc = 0; m_code = 0; m_single = 1'b0;
            e_en = 1'b0; e_do = 1'b0; e_valid = 1'b0; e_single = 1'b0; e_odd = 1'b0;
            e_trial = '0;
            q.delete();
        end else begin
            if (r) begin
                case (m_stage)
                    0: if (din) m_stage = 1;
                    1: begin m_single = din; m_stage = 2; end
                    2: begin
                        e_valid = 1'b1; e_single = m_single; e_odd = din;
                        if (m_single) diff = din ? ch1 : ch0;
                        else          diff = din ? (ch1 - ch0) : (ch0 - ch1);
                        m_code = (diff < 0) ? 0 : diff;
                        q.delete();
                        q.push_back(1'b0);
                        for (int k = CW - 1; k >= 0; k--) q.push_back(bit'((m_code >> k) & 1));
                        for (int k = 1; k < CW; k++)      q.push_back(bit'((m_code >> k) & 1));
                        m_stage = 3; m_rc = 0; m_fc = 0;
                    end
                    default: begin
                        m_rc++;
                        if (m_rc <= CW) begin
                            b = CW - m_rc;
                            e_trial = CW'(((m_code >> (b + 1)) << (b + 1)) | (1 << b));
                        end
                    end
                endcase
            end
            if (f && m_stage == 3) begin
                m_fc++;
                e_en = 1'b1;
                e_do = (q.size() > 0) ? q.pop_front() : 1'b0;
                if (m_fc >= 2 && m_fc <= CW + 1) begin
                    b = CW + 1 - m_fc;
                    e_trial = CW'((m_code >> b) << b);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(32'(dout_en), 32'(e_en), cs_n ? "R1 dout_en" : "R5 dout_en");
            if (e_en) chk(32'(dout), 32'(e_do), "R7/R8 dout");
            chk(32'(trial_code), 32'(e_trial), cs_n ? "R1 trial" : "R6 trial");
            chk(32'(sel_valid), 32'(e_valid), "R3 sel_valid");
            chk(32'(sel_single), 32'(e_single), "R3 sel_single");
            chk(32'(sel_odd), 32'(e_odd), "R3 sel_odd");
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse();
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic run_conv(input int pre, input bit sgl, input bit odd, input int after,
                            output logic [CW-1:0] msb, output logic [CW-1:0] lsb,
                            output bit settle_ok);
        logic s;
        msb = '0; lsb = '0; settle_ok = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < pre + 3; i++) begin
            din = (i < pre) ? 1'b0 : (i == pre) ? 1'b1 : (i == pre + 1) ? sgl : odd;
            pulse();
        end
        for (int j = 1; j <= after; j++) begin
            din = 1'((j ^ (j >> 2)) & 1);
            repeat (H) @(negedge clk);
            s = dout;
            if (j == 1) settle_ok = dout_en && (dout == 1'b0);
            if (j >= 2 && j <= CW + 1) msb[CW + 1 - j] = s;
            if (j >= CW + 2 && j <= 2 * CW) lsb[j - CW - 1] = s;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        lsb[0] = msb[0];
    endtask

    task automatic release_cs();
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(32'(dout_en), 32'd0, "R1 released dout_en");
        chk(32'(sel_valid), 32'd0, "R1 released sel_valid");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [CW-1:0] msb, lsb;
        bit st;
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; ch0 = 0; ch1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk(32'(dout_en), 0, "R1 reset dout_en");
        chk(32'(trial_code), 0, "R1 reset trial");
        chk(32'(sel_valid), 0, "R1 reset sel_valid");

        // single-ended channel 0
        ch0 = 'hA5; ch1 = 'h11;
        run_conv(0, 1'b1, 1'b0, 18, msb, lsb, st);
        chk(32'(st), 1, "R5 settle low");
        chk(32'(msb), 'hA5, "R7 msb-first code");
        chk(32'(lsb), 'hA5, "R8 lsb-first replay");
        chk(32'(trial_code), 'hA5, "R6 final trial");
        release_cs();

        // leading zeros before start, channel 1
        ch0 = 'hF0; ch1 = 'h3C;
        run_conv(3, 1'b1, 1'b1, 18, msb, lsb, st);
        chk(32'(msb), 'h3C, "R2 code after preamble");
        chk(32'(sel_single), 1, "R4 mode kept despite din");
        chk(32'(sel_odd), 1, "R4 select kept despite din");
        release_cs();

        // differential, channel 0 positive
        ch0 = 200; ch1 = 50;
        run_conv(1, 1'b0, 1'b0, 18, msb, lsb, st);
        chk(32'(msb), 150, "R3 differential code");
        chk(32'(lsb), 150, "R8 differential replay");
        release_cs();

        // differential, swapped polarity, negative
        run_conv(0, 1'b0, 1'b1, 18, msb, lsb, st);
        chk(32'(msb), 0, "R9 negative msb");
        chk(32'(lsb), 0, "R9 negative lsb");
        release_cs();

        // extremes
        ch0 = 255;
        run_conv(0, 1'b1, 1'b0, 18, msb, lsb, st);
        chk(32'(msb), 'hFF, "R7 full scale");
        release_cs();
        ch0 = 0;
        run_conv(0, 1'b1, 1'b0, 18, msb, lsb, st);
        chk(32'(msb), 0, "R9 zero input");
        release_cs();

        // abort mid-search, then a fresh conversion
        ch0 = 'h5A;
        run_conv(0, 1'b1, 1'b0, 5, msb, lsb, st);
        release_cs();
        chk(32'(trial_code), 0, "R1 abort clears trial");
        run_conv(0, 1'b1, 1'b0, 18, msb, lsb, st);
        chk(32'(msb), 'h5A, "R10 restart after toggle");
        release_cs();

        // extra edges after completion must not restart
        ch1 = 'h81;
        run_conv(0, 1'b1, 1'b1, 24, msb, lsb, st);
        chk(32'(msb), 'h81, "R7 code before extra edges");
        for (int k = 0; k < 6; k++) begin
            din = 1'(k & 1);
            pulse();
        end
        repeat (H) @(negedge clk);
        chk(32'(dout_en), 1, "R10 still driving");
        chk(32'(dout), 0, "R10 no new stream");
        chk(32'(trial_code), 'h81, "R10 trial untouched");
        chk(32'(sel_odd), 1, "R10 select untouched");
        release_cs();

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule